// File: doc/BRIEF.md
# Local Surface-Code Clique Decoder

This block is one syndrome-processing unit for a rotated surface-code patch, centred on a single ancilla. Each job brings in one already-filtered central syndrome bit, the syndrome bits of up to four nearest-neighbour ancillas and a position class. The unit resolves short spatial error chains on its own. It corrects a chain of length one when the centre fires against an odd neighbour parity. It corrects the recognised length-two shapes when the centre is quiet and the neighbour parity is even. Each correction leaves a flip request for the adjacent data qubits, and a pattern it cannot resolve is marked complex so that an external decoder can take it.

The work is done by a small state machine that walks one job through fixed states. `S_IDLE` waits for `in_valid`. `S_LEN1` applies the interior length-one rule. `S_LEN2` applies the interior length-two rule. `S_BOUND` applies the reduced rule for edge and corner units. `S_MARK` reports the outcome. The transitions are `S_IDLE→S_LEN1` on an accepted job, then `S_LEN1→S_LEN2→S_BOUND→S_MARK` unconditionally, then `S_MARK→S_IDLE`. The local syndrome copy is rewritten after every correction, so each later state sees only what the earlier states left behind.

Neighbour index order is N=bit 0, E=bit 1, S=bit 2, W=bit 3. The `flip` bit with the same index names the data qubit between the centre and that neighbour. Position classes are 0 for interior (N, E, S and W exist), 1 for edge (N, E and S exist), 2 for corner (N and E exist) and 3, which is handled as a corner.

Top module: `clq_decoder`

## Requirements
- R1: While reset is low and in the first cycle after it, `flip_valid`, `flip`, `done` and `complex_out` are all 0.
- R2: An interior job with centre 1 and odd parity over N,E,S,W gets a length-one correction. `flip` has a single bit set, at the lowest-index set neighbour, and `flip_valid` is high in the cycle after the first clock edge that follows the capture edge.
- R3: An interior job with centre 0 and neighbour pattern 4'b1010 (E,W), 4'b0101 (N,S), 4'b0011 (N,E), 4'b1100 (S,W) or 4'b1111 (all) gets a length-two correction. `flip` equals that pattern and is shown with `flip_valid` after the second edge past capture.
- R4: An interior job whose centre is 1 and whose neighbour parity is even produces no flip, even when its neighbour bits form one of the R3 shapes.
- R5: After any correction, the centre and all neighbour bits are cleared, so a job fully resolved by a correction reports `complex_out`=0.
- R6: Edge and corner jobs skip the interior rules. With centre 1 and odd parity over the existing neighbours, they get one flip at the lowest-index existing set neighbour, shown after the third edge past capture.
- R7: Neighbour inputs that do not exist for the position class (W for edge, S and W for corner) have no effect on parity, flips or `complex_out`.
- R8: A job that leaves the centre or any existing neighbour bit set after all correction states reports `complex_out`=1. Such a job produces no flip.
- R9: `done` is high for exactly one cycle, after the fourth clock edge past the capture edge. `complex_out` is valid in that same cycle.
- R10: A job produces at most one `flip_valid` pulse, one cycle long, and never in the same cycle as `done`.
- R11: `in_valid` is ignored while a job is in progress. A new job is accepted only from `S_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start a job; sampled only in S_IDLE |
| in_centre | input | 1 | Filtered central syndrome bit |
| in_nbr | input | 4 | Neighbour syndromes, N=0 E=1 S=2 W=3 |
| in_pos | input | 2 | Position class: 0 interior, 1 edge, 2/3 corner |
| flip_valid | output | 1 | One-cycle strobe qualifying `flip` |
| flip | output | 4 | Data-qubit flip request, same index as neighbours |
| done | output | 1 | One-cycle end-of-job strobe |
| complex_out | output | 1 | Residual syndrome remains; forward off-chip |

## Verification
Counting from the edge that captures a job, the length-one flip is due after edge 1, the length-two flip after edge 2, the boundary flip after edge 3, and `done` with `complex_out` after edge 4. The bench drives inputs on falling edges and samples on each of the five falling edges that follow. It records which of those samples carried the flip and compares that index with the state the requirement names, so a flip one cycle late or early is a failure even when its value is right. The checker enforces the same schedule with its own cycle counter from the accepted request.

// File: rtl/clq_pkg.sv
package clq_pkg;

    localparam int NBR_N   = 4;
    localparam int POS_W   = 2;
    localparam int PAT_N   = 5;

    typedef enum logic [POS_W-1:0] {
        POS_INNER  = 2'd0,
        POS_EDGE   = 2'd1,
        POS_CORNER = 2'd2,
        POS_SPARE  = 2'd3
    } pos_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LEN1  = 3'd1,
        S_LEN2  = 3'd2,
        S_BOUND = 3'd3,
        S_MARK  = 3'd4
    } state_e;

    // Length-two shapes, neighbour order N,E,S,W at bits 0..3.
    localparam logic [NBR_N-1:0] PAIR_SHAPES [PAT_N] = '{
        4'b1010,   // E and W
        4'b0101,   // N and S
        4'b0011,   // N and E
        4'b1100,   // S and W
        4'b1111    // all four
    };

    // Which neighbours exist for each position class.
    function automatic logic [NBR_N-1:0] nbr_mask(input pos_e p);
        logic [NBR_N-1:0] m;
        unique case (p)
            POS_INNER: m = 4'b1111;
            POS_EDGE:  m = 4'b0111;
            default:   m = 4'b0011;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/clq_len1_unit.sv
module clq_len1_unit #(
    parameter int NB = 4
) (
    input  logic          enable,
    input  logic          centre,
    input  logic [NB-1:0] nbr,
    input  logic [NB-1:0] mask,
    output logic          fire,
    output logic [NB-1:0] flip
);
    logic [NB-1:0] live;
    logic          odd;

    assign live = nbr & mask;
    assign odd  = ^live;
    assign fire = enable & centre & odd;

    // lowest-index live neighbour wins
    always_comb begin
        flip = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (live[i]) begin
                flip    = '0;
                flip[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/clq_len2_unit.sv
module clq_len2_unit
    import clq_pkg::*;
(
    input  logic             enable,
    input  logic             centre,
    input  logic [NBR_N-1:0] nbr,
    output logic             fire,
    output logic [NBR_N-1:0] flip
);
    logic [PAT_N-1:0] hit;

    generate
        for (genvar k = 0; k < PAT_N; k++) begin : g_shape
            assign hit[k] = (nbr == PAIR_SHAPES[k]);
        end
    endgenerate

    assign fire = enable & ~centre & ~(^nbr) & (|hit);
    assign flip = nbr;
endmodule

// File: rtl/clq_residue.sv
module clq_residue #(
    parameter int NB = 4
) (
    input  logic          centre,
    input  logic [NB-1:0] nbr,
    input  logic [NB-1:0] mask,
    output logic          left_over
);
    assign left_over = centre | (|(nbr & mask));
endmodule

// File: rtl/clq_decoder.sv
module clq_decoder
    import clq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_centre,
    input  logic [NBR_N-1:0] in_nbr,
    input  logic [POS_W-1:0] in_pos,
    output logic             flip_valid,
    output logic [NBR_N-1:0] flip,
    output logic             done,
    output logic             complex_out
);
    state_e           state_q, state_d;
    logic             centre_q;
    logic [NBR_N-1:0] nbr_q;
    pos_e             pos_q;

    logic [NBR_N-1:0] mask_cur, mask_l1;
    logic             inner;
    logic             l1_en, l1_fire, l2_en, l2_fire, left_over;
    logic [NBR_N-1:0] l1_flip, l2_flip;

    assign mask_cur = nbr_mask(pos_q);
    assign inner    = (pos_q == POS_INNER);
    assign l1_en    = (state_q == S_LEN1 && inner) || (state_q == S_BOUND && !inner);
    assign mask_l1  = (state_q == S_LEN1) ? {NBR_N{1'b1}} : mask_cur;
    assign l2_en    = (state_q == S_LEN2) && inner;

    clq_len1_unit #(.NB(NBR_N)) u_len1 (
        .enable (l1_en),
        .centre (centre_q),
        .nbr    (nbr_q),
        .mask   (mask_l1),
        .fire   (l1_fire),
        .flip   (l1_flip)
    );

    clq_len2_unit u_len2 (
        .enable (l2_en),
        .centre (centre_q),
        .nbr    (nbr_q),
        .fire   (l2_fire),
        .flip   (l2_flip)
    );

    clq_residue #(.NB(NBR_N)) u_res (
        .centre    (centre_q),
        .nbr       (nbr_q),
        .mask      (mask_cur),
        .left_over (left_over)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_valid) state_d = S_LEN1;
            S_LEN1:  state_d = S_LEN2;
            S_LEN2:  state_d = S_BOUND;
            S_BOUND: state_d = S_MARK;
            S_MARK:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // local syndrome copy, rewritten after each correction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            centre_q <= 1'b0;
            nbr_q    <= '0;
            pos_q    <= POS_INNER;
        end else if (state_q == S_IDLE && in_valid) begin
            centre_q <= in_centre;
            nbr_q    <= in_nbr;
            pos_q    <= pos_e'(in_pos);
        end else if (l1_fire) begin
            centre_q <= 1'b0;
            nbr_q    <= '0;
        end else if (l2_fire) begin
            nbr_q    <= '0;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_valid  <= 1'b0;
            flip        <= '0;
            done        <= 1'b0;
            complex_out <= 1'b0;
        end else begin
            flip_valid <= 1'b0;
            flip       <= '0;
            done       <= 1'b0;
            unique case (state_q)
                S_LEN1, S_BOUND: begin
                    if (l1_fire) begin
                        flip_valid <= 1'b1;
                        flip       <= l1_flip;
                    end
                end
                S_LEN2: begin
                    if (l2_fire) begin
                        flip_valid <= 1'b1;
                        flip       <= l2_flip;
                    end
                end
                S_MARK: begin
                    done        <= 1'b1;
                    complex_out <= left_over;
                end
                S_IDLE: begin
                    if (in_valid) complex_out <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/clq_decoder_chk.sv
module clq_decoder_chk
    import clq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             flip_valid,
    input logic [NBR_N-1:0] flip,
    input logic             done,
    input logic             complex_out
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 3'd0;
        end else if ((age == 3'd0 || age == 3'd5) && in_valid) begin
            age <= 3'd1;
        end else if (age == 3'd5) begin
            age <= 3'd0;
        end else if (age != 3'd0) begin
            age <= age + 3'd1;
        end
    end

    p_done_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> age == 3'd5);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_flip_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flip_valid |-> (age >= 3'd2 && age <= 3'd4));
    p_flip_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flip_valid |=> !flip_valid);
    p_flip_not_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flip_valid |-> !done);
    p_flip_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flip_valid |-> flip != '0);
    p_flip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_valid |-> flip == '0);
    p_flip_single_len1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_valid && age == 3'd4) |-> $onehot0(flip));
endmodule

bind clq_decoder clq_decoder_chk u_clq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .flip_valid  (flip_valid),
    .flip        (flip),
    .done        (done),
    .complex_out (complex_out)
);

// File: tb/test_clq_decoder.sv
module test_clq_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_centre = 1'b0;
    logic [3:0] in_nbr = '0;
    logic [1:0] in_pos = '0;
    logic       flip_valid, done, complex_out;
    logic [3:0] flip;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    clq_decoder i_clq_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_centre(in_centre),
        .in_nbr(in_nbr), .in_pos(in_pos), .flip_valid(flip_valid), .flip(flip),
        .done(done), .complex_out(complex_out)
    );

    // {pos, centre, nbr, flip_slot(0 none,1..3), flip, complex}
    localparam int NV = 20;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 1'b1, 4'b0001, 2'd1, 4'b0001, 1'b0},  // R2
        {2'd0, 1'b1, 4'b0100, 2'd1, 4'b0100, 1'b0},  // R2
        {2'd0, 1'b1, 4'b1110, 2'd1, 4'b0010, 1'b0},  // R2 priority
        {2'd0, 1'b0, 4'b1010, 2'd2, 4'b1010, 1'b0},  // R3
        {2'd0, 1'b0, 4'b0101, 2'd2, 4'b0101, 1'b0},  // R3
        {2'd0, 1'b0, 4'b0011, 2'd2, 4'b0011, 1'b0},  // R3
        {2'd0, 1'b0, 4'b1100, 2'd2, 4'b1100, 1'b0},  // R3
        {2'd0, 1'b0, 4'b1111, 2'd2, 4'b1111, 1'b0},  // R3
        {2'd0, 1'b0, 4'b1001, 2'd0, 4'b0000, 1'b1},  // R8
        {2'd0, 1'b1, 4'b0000, 2'd0, 4'b0000, 1'b1},  // R8
        {2'd0, 1'b0, 4'b0010, 2'd0, 4'b0000, 1'b1},  // R8
        {2'd0, 1'b0, 4'b0000, 2'd0, 4'b0000, 1'b0},  // R5
        {2'd0, 1'b1, 4'b0011, 2'd0, 4'b0000, 1'b1},  // R4
        {2'd1, 1'b1, 4'b0100, 2'd3, 4'b0100, 1'b0},  // R6
        {2'd1, 1'b1, 4'b1100, 2'd3, 4'b0100, 1'b0},  // R7
        {2'd1, 1'b0, 4'b1010, 2'd0, 4'b0000, 1'b1},  // R6
        {2'd2, 1'b1, 4'b0010, 2'd3, 4'b0010, 1'b0},  // R6
        {2'd2, 1'b1, 4'b1101, 2'd3, 4'b0001, 1'b0},  // R7
        {2'd2, 1'b1, 4'b0011, 2'd0, 4'b0000, 1'b1},  // R6
        {2'd3, 1'b1, 4'b1001, 2'd3, 4'b0001, 1'b0}   // R7
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one job; observe five falling edges after the request.
    task automatic run_job(input logic [1:0] pos, input logic c, input logic [3:0] n,
                           input int exp_slot, input logic [3:0] exp_flip,
                           input logic exp_cx, input string req,
                           input bit poke_busy);
        int slot = 0;
        int pulses = 0;
        logic [3:0] seen = '0;
        logic cx = 1'b0;
        int done_at = 0;
        in_pos = pos; in_centre = c; in_nbr = n; in_valid = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (poke_busy && i == 2) begin
                in_valid = 1'b1; in_centre = 1'b0; in_nbr = 4'b1111; in_pos = 2'd0;
            end
            if (flip_valid) begin
                pulses++; slot = i - 1; seen = flip;
            end
            if (done) begin
                done_at = i; cx = complex_out;
            end
        end
        in_valid = 1'b0;
        check(pulses == (exp_slot != 0 ? 1 : 0) && slot == exp_slot && seen == exp_flip,
              req, "flip slot/value", {slot, 4'h0, seen}, {exp_slot, 4'h0, exp_flip});
        check(done_at == 5 && cx == exp_cx, req, "done/complex",
              {done_at, 3'b0, cx}, {5, 3'b0, exp_cx});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!flip_valid && flip == 4'b0 && !done && !complex_out, "R1", "in reset",
              {flip_valid, flip, done, complex_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!flip_valid && flip == 4'b0 && !done && !complex_out, "R1", "after reset",
              {flip_valid, flip, done, complex_out}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [13:0] e;
            e = VEC[v];
            run_job(e[13:12], e[11], e[10:7], int'(e[6:5]), e[4:1], e[0],
                    $sformatf("vec%0d R2-R8", v), 1'b0);
        end

        // R11: request while busy must be ignored
        run_job(2'd0, 1'b1, 4'b0001, 1, 4'b0001, 1'b0, "R11 busy", 1'b1);
        begin
            int extra = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (done || flip_valid) extra++;
            end
            check(extra == 0, "R11", "no second job", extra, 0);
        end

        // R5: complex cleared by a resolved job after a complex one
        run_job(2'd0, 1'b1, 4'b0000, 0, 4'b0000, 1'b1, "R8 before", 1'b0);
        run_job(2'd0, 1'b0, 4'b1111, 2, 4'b1111, 1'b0, "R5 after", 1'b0);

        // R1: reset in the middle of a job kills it
        in_pos = 2'd0; in_centre = 1'b1; in_nbr = 4'b0001; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int act = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (done || flip_valid) act++;
            end
            check(act == 0, "R1", "job dropped by reset", act, 0);
        end

        // R9: back-to-back jobs, both on schedule
        run_job(2'd1, 1'b1, 4'b0001, 3, 4'b0001, 1'b0, "R9 first", 1'b0);
        run_job(2'd2, 1'b1, 4'b0010, 3, 4'b0010, 1'b0, "R9 second", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule